// File: doc/BRIEF.md
# Multi-cycle Processor Control FSM

This block sequences a 32-bit processor that keeps one shared memory port and one ALU busy across several cycles per instruction. A finite state machine reads the opcode held in the instruction register, together with the zero and overflow flags from the ALU and an undefined-function flag from the ALU decoder. From these it raises one bundle of strobes each cycle. The strobes enable the PC, instruction, memory-data, operand, ALU-result, exception-PC and cause registers, steer the operand and next-PC multiplexers, select the ALU operation class, and pulse the memory read and write lines. The datapath registers and a 32-entry register file sit beside the controller, so the whole unit can be exercised through its memory port.

Each instruction class takes its own number of cycles. Every instruction starts with a fetch cycle and a decode cycle. A jump or a branch ends in the third cycle, register arithmetic and stores in the fourth, and loads in the fifth. Two conditions are trapped: an unknown opcode or function code, and signed overflow on a register add or subtract. A trap stores the address of the faulting instruction and a cause code, sets a privileged flag, and sends the PC to a fixed handler entry.

Top module: `mcpu_core`

## Requirements
- R1: While rstN is low, pcOut, epcOut and causeOut are 0, privMode is 0, and ctlState is 0, the code of the fetch cycle.
- R2: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], immediate [15:0] and jump target [25:0]. In every fetch cycle memRd is high with memAddr equal to the PC. At the end of the cycle the word read is latched as the instruction and the PC advances by 4. The next cycle is always decode.
- R3: Opcode 0 is register arithmetic: funct 32 add, 34 subtract, 36 AND, 37 OR, 42 signed set-less-than (result 1 or 0). The result is written to rd, and the instruction takes 4 cycles.
- R4: Opcode 35 loads the word at rs plus the sign-extended immediate into rt, and takes 5 cycles.
- R5: Opcode 43 writes rt to rs plus the sign-extended immediate with one memWr pulse, and takes 4 cycles.
- R6: Opcode 4 branches when rs equals rt to the address of the next instruction plus the sign-extended immediate times 4. It leaves the PC at the next instruction otherwise, and takes 3 cycles either way.
- R7: Opcode 2 jumps to {top 4 bits of the next instruction's address, target, 2'b00}, and takes 3 cycles.
- R8: Any opcode other than 0, 2, 4, 35, 43 traps after decode (3 cycles). An opcode-0 word with a funct outside the list of R3 traps after its execute cycle (4 cycles). Both set cause 0.
- R9: Signed overflow of a register add or subtract traps with cause 1, after 4 cycles, and rd keeps its old value. Set-less-than never traps.
- R10: A trap loads epcOut with the address of the faulting instruction, sets privMode (held until reset), and loads the PC with 0x80000180. Fetch resumes there.
- R11: Register 0 always reads as zero, and writes to it are dropped.
- R12: memRd and memWr are never high together, and memWr is high only in the store's memory cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| memAddr | output | 32 | Shared memory byte address |
| memWrData | output | 32 | Store data |
| memRdData | input | 32 | Memory read data, combinational from memAddr |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| pcOut | output | 32 | Current program counter |
| epcOut | output | 32 | Address of the last trapped instruction |
| causeOut | output | 32 | Trap cause code |
| privMode | output | 1 | Set on a trap |
| ctlState | output | 4 | Controller state code, 0 = fetch |

## Verification
Assertions check the following on every cycle:
- the PC advances by four after each fetch;
- a not-taken branch holds the PC;
- a trap lands on the handler address with the exception PC one word behind the trapping PC;
- an overflowing register add or subtract always enters the overflow trap state;
- the memory strobes never overlap, and a store only follows address generation.

Only the bench's scenarios can show the rest:
- the arithmetic results and the suppressed write-back;
- the per-class cycle counts;
- the exhaustive opcode and function-code sweeps for undefined encodings;
- branch and load/store offsets with negative immediates;
- the handling of register 0.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_JUMP  = 6'd2;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  localparam logic CAUSE_UNDEF = 1'b0;
  localparam logic CAUSE_OVF   = 1'b1;

  typedef enum logic [1:0] {AOP_ADD = 2'b00, AOP_SUB = 2'b01, AOP_FUNCT = 2'b10} aluOp_e;
  typedef enum logic [2:0] {
    ALU_AND = 3'b000, ALU_OR = 3'b001, ALU_ADD = 3'b010, ALU_SUB = 3'b110, ALU_SLT = 3'b111
  } aluCode_e;
  typedef enum logic [1:0] {SRCB_REG, SRCB_FOUR, SRCB_IMM, SRCB_BROFF} srcB_e;
  typedef enum logic [1:0] {PCSRC_ALU, PCSRC_ALUOUT, PCSRC_JUMP, PCSRC_TRAP} pcSrc_e;

  typedef enum logic [3:0] {
    S_FETCH   = 4'd0,
    S_DECODE  = 4'd1,
    S_MEMADR  = 4'd2,
    S_MEMRD   = 4'd3,
    S_LDWB    = 4'd4,
    S_MEMWR   = 4'd5,
    S_REXEC   = 4'd6,
    S_RWB     = 4'd7,
    S_BRANCH  = 4'd8,
    S_JUMP    = 4'd9,
    S_EXCUND  = 4'd10,
    S_EXCOVF  = 4'd11
  } ctlState_e;

  typedef struct packed {
    logic    pcLoad;
    logic    pcWriteCond;
    logic    iorD;
    logic    memRead;
    logic    memWrite;
    logic    irWrite;
    logic    aEn;
    logic    bEn;
    logic    mdrEn;
    logic    aluOutEn;
    logic    regWrite;
    logic    regDst;
    logic    memToReg;
    logic    aluSrcA;
    srcB_e   aluSrcB;
    aluOp_e  aluOp;
    pcSrc_e  pcSource;
    logic    epcWrite;
    logic    causeWrite;
    logic    causeCode;
    logic    privSet;
  } ctlStrobes_t;
endpackage

// File: rtl/mcpu_aluctl.sv
module mcpu_aluctl
  import mcpu_pkg::*;
(
  input  aluOp_e     aluOp,
  input  logic [5:0] funct,
  output aluCode_e   code,
  output logic       functBad
);
  always_comb begin
    code = ALU_ADD;
    functBad = 1'b0;
    case (aluOp)
      AOP_ADD: code = ALU_ADD;
      AOP_SUB: code = ALU_SUB;
      AOP_FUNCT: begin
        case (funct)
          FN_ADD:  code = ALU_ADD;
          FN_SUB:  code = ALU_SUB;
          FN_AND:  code = ALU_AND;
          FN_OR:   code = ALU_OR;
          FN_SLT:  code = ALU_SLT;
          default: functBad = 1'b1;
        endcase
      end
      default: code = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/mcpu_alu.sv
module mcpu_alu
  import mcpu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  aluCode_e     code,
  output logic [W-1:0] y,
  output logic         zero,
  output logic         ovf
);
  logic [W-1:0] sum;
  logic [W-1:0] diff;

  assign sum  = a + b;
  assign diff = a - b;

  always_comb begin
    ovf = 1'b0;
    case (code)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: begin
        y   = sum;
        ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
      end
      ALU_SUB: begin
        y   = diff;
        ovf = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
      end
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = sum;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/mcpu_datapath.sv
module mcpu_datapath
  import mcpu_pkg::*;
#(
  parameter int              REG_N        = 32,
  parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h8000_0180
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobes_t     st,
  output logic [5:0]      opcode,
  output logic            aluZero,
  output logic            aluOvf,
  output logic            functBad,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWrData,
  input  logic [XLEN-1:0] memRdData,
  output logic [XLEN-1:0] pcOut,
  output logic [XLEN-1:0] epcOut,
  output logic [XLEN-1:0] causeOut,
  output logic            privMode
);
  localparam int REG_AW = $clog2(REG_N);

  logic [XLEN-1:0] pc, ir, mdr, regA, regB, aluOut, epc, cause;
  logic            priv;
  logic [XLEN-1:0] rf [REG_N];
  logic [XLEN-1:0] sext, srcA, srcB, aluY, pcNext, wrData;
  logic [REG_AW-1:0] rsIdx, rtIdx, wrIdx;
  aluCode_e        aluCode;

  assign opcode = ir[31:26];
  assign sext   = {{(XLEN-16){ir[15]}}, ir[15:0]};
  assign rsIdx  = ir[21 +: REG_AW];
  assign rtIdx  = ir[16 +: REG_AW];
  assign wrIdx  = st.regDst ? ir[11 +: REG_AW] : rtIdx;
  assign wrData = st.memToReg ? mdr : aluOut;

  // register file, entry 0 tied to zero
  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign rf[g] = '0;
    end else begin : g_live
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) rf[g] <= '0;
        else if (st.regWrite && (wrIdx == REG_AW'(g))) rf[g] <= wrData;
      end
    end
  end

  assign srcA = st.aluSrcA ? regA : pc;
  always_comb begin
    case (st.aluSrcB)
      SRCB_REG:   srcB = regB;
      SRCB_FOUR:  srcB = XLEN'(4);
      SRCB_IMM:   srcB = sext;
      default:    srcB = {sext[XLEN-3:0], 2'b00};
    endcase
  end

  mcpu_aluctl u_aluctl (
    .aluOp   (st.aluOp),
    .funct   (ir[5:0]),
    .code    (aluCode),
    .functBad(functBad)
  );

  mcpu_alu #(.W(XLEN)) u_alu (
    .a   (srcA),
    .b   (srcB),
    .code(aluCode),
    .y   (aluY),
    .zero(aluZero),
    .ovf (aluOvf)
  );

  always_comb begin
    case (st.pcSource)
      PCSRC_ALU:    pcNext = aluY;
      PCSRC_ALUOUT: pcNext = aluOut;
      PCSRC_JUMP:   pcNext = {pc[XLEN-1:XLEN-4], ir[25:0], 2'b00};
      default:      pcNext = HANDLER_ADDR;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc     <= '0;
      ir     <= '0;
      mdr    <= '0;
      regA   <= '0;
      regB   <= '0;
      aluOut <= '0;
      epc    <= '0;
      cause  <= '0;
      priv   <= 1'b0;
    end else begin
      if (st.pcLoad)     pc     <= pcNext;
      if (st.irWrite)    ir     <= memRdData;
      if (st.mdrEn)      mdr    <= memRdData;
      if (st.aEn)        regA   <= rf[rsIdx];
      if (st.bEn)        regB   <= rf[rtIdx];
      if (st.aluOutEn)   aluOut <= aluY;
      if (st.epcWrite)   epc    <= aluY;
      if (st.causeWrite) cause  <= {{(XLEN-1){1'b0}}, st.causeCode};
      if (st.privSet)    priv   <= 1'b1;
    end
  end

  assign memAddr   = st.iorD ? aluOut : pc;
  assign memWrData = regB;
  assign pcOut     = pc;
  assign epcOut    = epc;
  assign causeOut  = cause;
  assign privMode  = priv;

  // R2: fetch advances the PC by one word
  p_fetch_incr_r2: assert property (@(posedge clk) disable iff (!rstN)
    st.irWrite |=> pc == $past(pc) + XLEN'(4));

  // R6: an untaken branch leaves the PC alone
  p_beq_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st.pcWriteCond && !aluZero) |=> $stable(pc));

  // R10: trap entry lands on the handler with EPC one word back
  p_handler_r10: assert property (@(posedge clk) disable iff (!rstN)
    st.epcWrite |=> (pc == HANDLER_ADDR) && (epc == $past(pc) - XLEN'(4)) && priv);

  // R12: memory strobes never overlap
  p_mem_excl_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(st.memRead && st.memWrite));
endmodule

// File: rtl/mcpu_control.sv
module mcpu_control
  import mcpu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  opcode,
  input  logic        aluZero,
  input  logic        aluOvf,
  input  logic        functBad,
  output ctlStrobes_t st,
  output logic [3:0]  stateCode
);
  ctlState_e state, nextState;
  logic      pcWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_FETCH;
    else       state <= nextState;
  end

  always_comb begin
    st        = '0;
    pcWrite   = 1'b0;
    nextState = S_FETCH;
    case (state)
      S_FETCH: begin
        st.memRead  = 1'b1;
        st.irWrite  = 1'b1;
        st.aluSrcB  = SRCB_FOUR;
        st.aluOp    = AOP_ADD;
        st.pcSource = PCSRC_ALU;
        pcWrite     = 1'b1;
        nextState   = S_DECODE;
      end
      S_DECODE: begin
        st.aEn      = 1'b1;
        st.bEn      = 1'b1;
        st.aluSrcB  = SRCB_BROFF;
        st.aluOp    = AOP_ADD;
        st.aluOutEn = 1'b1;
        case (opcode)
          OP_RTYPE:          nextState = S_REXEC;
          OP_LOAD, OP_STORE: nextState = S_MEMADR;
          OP_BEQ:            nextState = S_BRANCH;
          OP_JUMP:           nextState = S_JUMP;
          default:           nextState = S_EXCUND;
        endcase
      end
      S_MEMADR: begin
        st.aluSrcA  = 1'b1;
        st.aluSrcB  = SRCB_IMM;
        st.aluOp    = AOP_ADD;
        st.aluOutEn = 1'b1;
        nextState   = (opcode == OP_LOAD) ? S_MEMRD : S_MEMWR;
      end
      S_MEMRD: begin
        st.memRead = 1'b1;
        st.iorD    = 1'b1;
        st.mdrEn   = 1'b1;
        nextState  = S_LDWB;
      end
      S_LDWB: begin
        st.regWrite = 1'b1;
        st.memToReg = 1'b1;
        nextState   = S_FETCH;
      end
      S_MEMWR: begin
        st.memWrite = 1'b1;
        st.iorD     = 1'b1;
        nextState   = S_FETCH;
      end
      S_REXEC: begin
        st.aluSrcA  = 1'b1;
        st.aluSrcB  = SRCB_REG;
        st.aluOp    = AOP_FUNCT;
        st.aluOutEn = 1'b1;
        if (functBad)                          nextState = S_EXCUND;
        else if (opcode == OP_RTYPE && aluOvf) nextState = S_EXCOVF;
        else                                   nextState = S_RWB;
      end
      S_RWB: begin
        st.regWrite = 1'b1;
        st.regDst   = 1'b1;
        nextState   = S_FETCH;
      end
      S_BRANCH: begin
        st.aluSrcA     = 1'b1;
        st.aluSrcB     = SRCB_REG;
        st.aluOp       = AOP_SUB;
        st.pcWriteCond = 1'b1;
        st.pcSource    = PCSRC_ALUOUT;
        nextState      = S_FETCH;
      end
      S_JUMP: begin
        st.pcSource = PCSRC_JUMP;
        pcWrite     = 1'b1;
        nextState   = S_FETCH;
      end
      S_EXCUND, S_EXCOVF: begin
        st.aluSrcB    = SRCB_FOUR;
        st.aluOp      = AOP_SUB;
        st.epcWrite   = 1'b1;
        st.causeWrite = 1'b1;
        st.causeCode  = (state == S_EXCOVF) ? CAUSE_OVF : CAUSE_UNDEF;
        st.privSet    = 1'b1;
        st.pcSource   = PCSRC_TRAP;
        pcWrite       = 1'b1;
        nextState     = S_FETCH;
      end
      default: nextState = S_FETCH;
    endcase
    st.pcLoad = pcWrite | (st.pcWriteCond & aluZero);
  end

  assign stateCode = state;

  // R2: decode always follows fetch
  p_decode_next_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FETCH) |=> (state == S_DECODE));

  // R9: an overflowing register add/sub goes to the overflow trap, never write-back
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_REXEC && aluOvf && !functBad) |=> (state == S_EXCOVF));

  // R12: a store pulse only follows address generation
  p_store_after_addr_r12: assert property (@(posedge clk) disable iff (!rstN)
    st.memWrite |-> ($past(state) == S_MEMADR));

  // R8: undefined funct traps with the undefined cause
  p_undef_funct_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_REXEC && functBad) |=> (state == S_EXCUND));
endmodule

// File: rtl/mcpu_core.sv
module mcpu_core
  import mcpu_pkg::*;
#(
  parameter int              REG_N        = 32,
  parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h8000_0180
) (
  input  logic            clk,
  input  logic            rstN,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWrData,
  input  logic [XLEN-1:0] memRdData,
  output logic            memRd,
  output logic            memWr,
  output logic [XLEN-1:0] pcOut,
  output logic [XLEN-1:0] epcOut,
  output logic [XLEN-1:0] causeOut,
  output logic            privMode,
  output logic [3:0]      ctlState
);
  ctlStrobes_t st;
  logic [5:0]  opcode;
  logic        aluZero, aluOvf, functBad;

  mcpu_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .opcode   (opcode),
    .aluZero  (aluZero),
    .aluOvf   (aluOvf),
    .functBad (functBad),
    .st       (st),
    .stateCode(ctlState)
  );

  mcpu_datapath #(.REG_N(REG_N), .HANDLER_ADDR(HANDLER_ADDR)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .opcode   (opcode),
    .aluZero  (aluZero),
    .aluOvf   (aluOvf),
    .functBad (functBad),
    .memAddr  (memAddr),
    .memWrData(memWrData),
    .memRdData(memRdData),
    .pcOut    (pcOut),
    .epcOut   (epcOut),
    .causeOut (causeOut),
    .privMode (privMode)
  );

  assign memRd = st.memRead;
  assign memWr = st.memWrite;
endmodule

// File: tb/sim_mcpu_core.sv
module sim_mcpu_core;
  localparam logic [31:0] SENT = 32'hA5A5_A5A5;
  localparam int NCYC = 40;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN;
  logic [31:0] memAddr, memWrData, memRdData, pcOut, epcOut, causeOut;
  logic        memRd, memWr, privMode;
  logic [3:0]  ctlState;
  logic [31:0] mem [256];

  int nChk = 0, nFail = 0, nFetch = 0, nWr = 0, nClash = 0;
  int fetchAt [16];
  bit done = 1'b0;

  assign memRdData = mem[memAddr[9:2]];

  mcpu_core u0 (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWrData(memWrData),
    .memRdData(memRdData), .memRd(memRd), .memWr(memWr), .pcOut(pcOut),
    .epcOut(epcOut), .causeOut(causeOut), .privMode(privMode), .ctlState(ctlState)
  );

  function automatic logic [31:0] encR(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] encI(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] encJ(input logic [25:0] tgt);
    return {6'd2, tgt};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chkLen(input int k, input int expLen, input string tag);
    int act;
    act = (nFetch > k + 1) ? fetchAt[k+1] - fetchAt[k] : -1;
    chk(act == expLen, tag, 32'(act), 32'(expLen));
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = SENT;
    mem[96] = encI(6'd43, 0, 3, 16'h010C);   // handler: store r3 to 0x10C
    mem[97] = encJ(26'h61);                  // handler: spin at 0x80000184
  endtask

  task automatic runProg(input int n);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    nFetch = 0;
    nWr = 0;
    for (int c = 0; c < n; c++) begin
      if (ctlState == 4'd0 && nFetch < 16) begin
        fetchAt[nFetch] = c;
        nFetch++;
      end
      if (memRd && memWr) nClash++;
      if (memWr) begin
        nWr++;
        mem[memAddr[9:2]] = memWrData;
      end
      @(negedge clk);
    end
  endtask

  task automatic refAlu(input logic [5:0] fn, input logic [31:0] x, input logic [31:0] y,
                        output logic [31:0] res, output bit ovf, output bit bad);
    ovf = 1'b0;
    bad = 1'b0;
    res = '0;
    case (fn)
      6'd32: begin res = x + y; ovf = (x[31] == y[31]) && (res[31] != x[31]); end
      6'd34: begin res = x - y; ovf = (x[31] != y[31]) && (res[31] != x[31]); end
      6'd36: res = x & y;
      6'd37: res = x | y;
      6'd42: res = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      default: bad = 1'b1;
    endcase
  endtask

  // program: lw r1; lw r2; R-op r3; sw r3 -> 0x108; j self
  task automatic arithRun(input logic [5:0] fn, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] res;
    bit ovf, bad;
    refAlu(fn, x, y, res, ovf, bad);
    clearMem();
    mem[64] = x;
    mem[65] = y;
    mem[0] = encI(6'd35, 0, 1, 16'h0100);
    mem[1] = encI(6'd35, 0, 2, 16'h0104);
    mem[2] = encR(1, 2, 3, fn);
    mem[3] = encI(6'd43, 0, 3, 16'h0108);
    mem[4] = encJ(26'd4);
    runProg(NCYC);
    chkLen(0, 5, "R4 load cycles");
    chkLen(1, 5, "R4 load cycles");
    chk(nWr == 1, "R12 single write", 32'(nWr), 32'd1);
    if (bad) begin
      chkLen(2, 4, "R8 undefined funct cycles");
      chk(causeOut == 32'd0, "R8 cause", causeOut, 32'd0);
      chk(epcOut == 32'd8, "R10 epc", epcOut, 32'd8);
      chk(privMode, "R10 priv", 32'(privMode), 32'd1);
      chk(mem[66] == SENT, "R8 no store", mem[66], SENT);
    end else if (ovf) begin
      chkLen(2, 4, "R9 overflow cycles");
      chk(causeOut == 32'd1, "R9 cause", causeOut, 32'd1);
      chk(epcOut == 32'd8, "R10 epc", epcOut, 32'd8);
      chk(privMode, "R10 priv", 32'(privMode), 32'd1);
      chk(mem[67] == 32'd0, "R9 rd not written", mem[67], 32'd0);
      chk(mem[66] == SENT, "R9 no store", mem[66], SENT);
      chk(pcOut[31:28] == 4'h8, "R7 jump keeps top bits", pcOut, 32'h8000_0184);
    end else begin
      chkLen(2, 4, "R3 rtype cycles");
      chkLen(3, 4, "R5 store cycles");
      chkLen(4, 3, "R7 jump cycles");
      chk(mem[66] == res, "R3 result", mem[66], res);
      chk(!privMode && causeOut == 0, "R10 no trap", {causeOut[30:0], privMode}, 32'd0);
      chk(pcOut == 32'd16 || pcOut == 32'd20, "R7 jump self", pcOut, 32'd16);
    end
  endtask

  logic [31:0] vals [6] = '{32'd0, 32'd1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678};
  logic [5:0]  fns  [5] = '{6'd32, 6'd34, 6'd36, 6'd37, 6'd42};

  initial begin
    #1_500_000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk + 1, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    clearMem();
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk(pcOut == 0 && epcOut == 0 && causeOut == 0, "R1 reset regs", pcOut | epcOut | causeOut, 32'd0);
    chk(!privMode && ctlState == 4'd0, "R1 reset state", {27'd0, ctlState, privMode}, 32'd0);
    chk(memRd && memAddr == 32'd0, "R2 fetch address", memAddr, 32'd0);

    // R3/R9: exhaustive op x operand sweep
    for (int k = 0; k < 5; k++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          arithRun(fns[k], vals[i], vals[j]);

    // R8: every funct code
    for (int f = 0; f < 64; f++) arithRun(6'(f), 32'd7, 32'd3);

    // R8: every opcode at instruction 2
    for (int op = 0; op < 64; op++) begin
      if (op == 0 || op == 2 || op == 4 || op == 35 || op == 43) continue;
      clearMem();
      mem[0] = encI(6'd35, 0, 1, 16'h0100);
      mem[1] = encI(6'd35, 0, 2, 16'h0104);
      mem[2] = encI(6'(op), 1, 2, 16'h0004);
      runProg(NCYC);
      chkLen(2, 3, "R8 undefined opcode cycles");
      chk(causeOut == 32'd0 && privMode, "R8 opcode cause", causeOut, 32'd0);
      chk(epcOut == 32'd8, "R10 epc opcode", epcOut, 32'd8);
      chk(mem[67] == 32'd0, "R10 handler runs", mem[67], 32'd0);
    end

    // R6: branch sweep, backward self-loop at the end
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++) begin
        clearMem();
        mem[64] = vals[i];
        mem[65] = vals[j];
        mem[0] = encI(6'd35, 0, 1, 16'h0100);
        mem[1] = encI(6'd35, 0, 2, 16'h0104);
        mem[2] = encI(6'd4, 1, 2, 16'h0001);
        mem[3] = encI(6'd43, 0, 1, 16'h0108);
        mem[4] = encI(6'd43, 0, 2, 16'h010C);
        mem[5] = encI(6'd4, 0, 0, 16'hFFFF);
        mem[6] = encI(6'd43, 0, 1, 16'h010C);
        runProg(NCYC);
        chkLen(2, 3, "R6 branch cycles");
        chk(mem[66] == ((i == j) ? SENT : vals[i]), "R6 taken/skip", mem[66], (i == j) ? SENT : vals[i]);
        chk(mem[67] == vals[j], "R6 backward loop", mem[67], vals[j]);
      end

    // R4/R5: negative offsets from a base register
    clearMem();
    mem[68] = 32'h0000_0130;
    mem[74] = 32'hCAFE_0123;
    mem[0] = encI(6'd35, 0, 4, 16'h0110);
    mem[1] = encI(6'd35, 4, 1, 16'hFFF8);
    mem[2] = encI(6'd43, 4, 1, 16'hFFFC);
    mem[3] = encJ(26'd3);
    runProg(NCYC);
    chk(mem[75] == 32'hCAFE_0123, "R4 R5 offset load/store", mem[75], 32'hCAFE_0123);
    chkLen(2, 4, "R5 store cycles");

    // R11: write to register 0 dropped
    clearMem();
    mem[64] = 32'd5;
    mem[65] = 32'd6;
    mem[0] = encI(6'd35, 0, 1, 16'h0100);
    mem[1] = encI(6'd35, 0, 2, 16'h0104);
    mem[2] = encR(1, 2, 0, 6'd32);
    mem[3] = encI(6'd43, 0, 0, 16'h0108);
    mem[4] = encJ(26'd4);
    runProg(NCYC);
    chk(mem[66] == 32'd0, "R11 reg0 zero", mem[66], 32'd0);

    chk(nClash == 0, "R12 strobe overlap", 32'(nClash), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule